// File: doc/BRIEF.md
# Converter Result Register Interlock

This block holds the most recent converter result and presents it to a processor as a low byte and a high byte. It keeps the two bytes of one read coherent. Reading the low byte freezes the stored result. Reading the high byte releases it. Any result that completes while the result is frozen is thrown away, not queued. A conversion flag records each completed conversion, including the ones that were thrown away. Software clears the flag with a clear strobe.

The stored result is `RES_W` bits wide, with a default of 10. The adjust input selects how it sits in the 16-bit pair. Right adjusted, it occupies bits 9:0. Left adjusted, it occupies bits 15:6. All unused bits read as zero. In left-adjusted mode, a reader that needs 8 bits can read the high byte alone.

Top module: `conv_result_lock`

## Requirements
- R1: With `left_adj`=0 the word is {6'b0, result}, so `lo_byte`=result[7:0] and `hi_byte`={6'b0, result[9:8]}. With `left_adj`=1 the word is {result, 6'b0}, so `hi_byte`=result[9:2] and `lo_byte`={result[1:0], 6'b0}. Both bytes follow `left_adj` with no clock delay.
- R2: A one-cycle `rd_lo` pulse without `rd_hi` sets the lock at the next edge.
- R3: A `conv_done` pulse is discarded, and neither byte changes, in two cases: while the lock is set, or in the same cycle as `rd_lo` without `rd_hi`.
- R4: A `rd_hi` pulse releases the lock at the next edge. A `conv_done` in the same cycle as `rd_hi` is stored.
- R5: With the lock released and no `rd_lo`, a `conv_done` pulse stores `conv_data`, which is visible on the bytes after the next edge.
- R6: Every `conv_done` pulse sets `conv_flag` at the next edge, including a pulse whose result is discarded.
- R7: A `rd_hi` pulse with no earlier `rd_lo` leaves the lock released, so the next conversion is stored.
- R8: `flag_clr` clears `conv_flag` at the next edge. When `conv_done` and `flag_clr` arrive in the same cycle, the flag is set.
- R9: After reset both bytes are zero, the lock is released and `conv_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | Conversion-complete strobe |
| conv_data | input | RES_W | Result word accompanying conv_done |
| left_adj | input | 1 | 1 = left-adjusted presentation |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| flag_clr | input | 1 | Flag clear strobe |
| lo_byte | output | 8 | Low byte as read |
| hi_byte | output | 8 | High byte as read |
| conv_flag | output | 1 | Conversion-complete flag |

## Verification
Every possible 10-bit result is stored with the lock released. Each is checked in both adjust modes, which separates the two byte layouts and exposes any lost or misplaced bit. A spread of values then goes through a locked read with a competing conversion between the two byte reads. This distinguishes discarding from overwriting and shows that the flag still sets. Single-cycle collisions are driven separately: conversion with low read, conversion with high read, high read alone, and conversion with flag clear. Each collision separates the intended priority from its opposite.

// File: rtl/conv_result_lock.sv
module conv_result_lock #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             left_adj,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic             flag_clr,
  output logic [7:0]       lo_byte,
  output logic [7:0]       hi_byte,
  output logic             conv_flag
);
  localparam int PAD = 16 - RES_W;

  logic [RES_W-1:0] res_q;
  logic             lock_q;
  logic             flag_q;
  logic             accept;
  logic [15:0]      word;

  assign accept = conv_done & (rd_hi | (~lock_q & ~rd_lo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      lock_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (accept)
        res_q <= conv_data;
      if (rd_hi)
        lock_q <= 1'b0;
      else if (rd_lo)
        lock_q <= 1'b1;
      flag_q <= conv_done | (flag_q & ~flag_clr);
    end
  end

  assign word      = left_adj ? {res_q, {PAD{1'b0}}} : {{PAD{1'b0}}, res_q};
  assign lo_byte   = word[7:0];
  assign hi_byte   = word[15:8];
  assign conv_flag = flag_q;
endmodule

module conv_result_lock_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_done,
  input logic [RES_W-1:0] conv_data,
  input logic             left_adj,
  input logic             rd_lo,
  input logic             rd_hi,
  input logic             flag_clr,
  input logic [7:0]       lo_byte,
  input logic             conv_flag,
  input logic             lock_q,
  input logic [RES_W-1:0] res_q
);
  localparam int PAD = 16 - RES_W;

  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    left_adj |-> (lo_byte[PAD-1:0] == '0));

  p_lock_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> lock_q);

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_q || rd_lo) && !rd_hi) |=> $stable(res_q));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !lock_q);

  p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (rd_hi || (!lock_q && !rd_lo))) |=> (res_q == $past(conv_data)));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> conv_flag);

  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !conv_done) |=> !conv_flag);
endmodule

bind conv_result_lock conv_result_lock_chk #(.RES_W(RES_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
  .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr),
  .lo_byte(lo_byte), .conv_flag(conv_flag), .lock_q(lock_q), .res_q(res_q)
);

// File: tb/test_conv_result_lock.sv
module test_conv_result_lock;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             conv_done = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic             left_adj = 1'b0;
  logic             rd_lo = 1'b0;
  logic             rd_hi = 1'b0;
  logic             flag_clr = 1'b0;
  logic [7:0]       lo_byte;
  logic [7:0]       hi_byte;
  logic             conv_flag;

  int checks = 0;
  int errors = 0;

  conv_result_lock #(.RES_W(RES_W)) i_conv_result_lock (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr),
    .lo_byte(lo_byte), .hi_byte(hi_byte), .conv_flag(conv_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes starting at a falling edge
  task automatic cyc(input logic cd, input int data, input logic lo,
                     input logic hi, input logic clr);
    conv_done = cd; conv_data = data[RES_W-1:0];
    rd_lo = lo; rd_hi = hi; flag_clr = clr;
    @(negedge clk);
    conv_done = 0; rd_lo = 0; rd_hi = 0; flag_clr = 0;
  endtask

  // check both bytes against a value in both adjust modes
  task automatic check_val(input string req, input int v);
    int w;
    left_adj = 1'b0; #1;
    w = v;
    check(req, {hi_byte, lo_byte}, w);
    left_adj = 1'b1; #1;
    w = v * 64;
    check(req, {hi_byte, lo_byte}, w);
    left_adj = 1'b0; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check_val("R9", 0);
    check("R9 flag", int'(conv_flag), 0);

    // R1/R5/R6/R8 sweep over every result value
    for (int v = 0; v < (1 << RES_W); v++) begin
      cyc(1, v, 0, 0, 0);
      check_val("R1_R5", v);
      check("R6", int'(conv_flag), 1);
      cyc(0, 0, 0, 0, 1);
      check("R8", int'(conv_flag), 0);
    end

    // R2/R3/R4/R6 locked read with a competing conversion
    for (int v = 0; v < (1 << RES_W); v += 37) begin
      int other;
      other = (~v) & ((1 << RES_W) - 1);
      cyc(1, v, 0, 0, 1);
      cyc(0, 0, 1, 0, 1);
      cyc(1, other, 0, 0, 0);
      check_val("R3", v);
      check("R6 discarded", int'(conv_flag), 1);
      cyc(0, 0, 0, 1, 1);
      check_val("R4 hold", v);
      cyc(1, other, 0, 0, 0);
      check_val("R4", other);
    end

    // R3 conversion in the same cycle as the low read
    cyc(1, 10'h155, 0, 0, 0);
    cyc(1, 10'h2AA, 1, 0, 0);
    check_val("R3 same", 'h155);
    cyc(1, 10'h0F0, 0, 0, 0);
    check_val("R2 locked", 'h155);
    // R4 conversion in the same cycle as the high read
    cyc(1, 10'h3C3, 0, 1, 0);
    check_val("R4 same", 'h3C3);

    // R7 high read alone leaves the lock released
    cyc(0, 0, 0, 1, 0);
    cyc(1, 10'h01F, 0, 0, 0);
    check_val("R7", 'h01F);

    // R8 set wins over clear
    cyc(0, 0, 0, 0, 1);
    cyc(1, 10'h100, 0, 0, 1);
    check("R8 set wins", int'(conv_flag), 1);
    check_val("R5", 'h100);

    // R9 reset again mid-run
    rst_n = 1'b0; #1;
    check_val("R9 rerst", 0);
    check("R9 flag", int'(conv_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1, 10'h2B4, 0, 0, 0);
    check_val("R9 unlocked", 'h2B4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule